// File: doc/BRIEF.md
# Segmented Word Stack Engine

This block performs stack operations for a 16-bit processor whose memory is addressed in bytes. It has four commands. PUSH stores a word. POP retrieves a word. CALL stores a return address and then redirects the program counter. RET retrieves a word and places it in the program counter. Every word moves as two single-byte transfers over a byte-wide memory port, one transfer per cycle. A short state sequencer orders the two transfers.

Each byte address is 20 bits wide. It is the stack segment value shifted left by four bits, plus a 16-bit offset taken from the stack pointer. A stored word is laid out with its high byte just below the pointer and its low byte two below the pointer. The pointer then moves down by two. A retrieval reads the low byte at the pointer, then the high byte one above it, and then raises the pointer by two.

The surrounding core starts a command with a one-cycle request. While the engine is busy it ignores further requests. When a command completes, the engine gives a one-cycle done pulse.

Top module: `seg_stack_unit`

## Requirements
- R1: After reset: busy and done are 0; sp_out, ss_out, pc_out and pop_data are 0; mem_we and mem_re are 0.
- R2: A PUSH (cmd_op 2'b00) runs two write cycles in a fixed order. The first cycle after acceptance writes push_data[15:8] at offset SP-1. The next cycle writes push_data[7:0] at offset SP-2. mem_we and mem_re are never both high.
- R3: When a PUSH or CALL completes, sp_out equals the SP value from before the command minus 2.
- R4: mem_addr = (SS × 16 + offset) mod 2^20. All offset arithmetic wraps mod 2^16, so an offset below zero continues from 0xFFFF within the same segment.
- R5: A POP (cmd_op 2'b01) reads the low byte at offset SP in the first cycle after acceptance and the high byte at SP+1 in the next cycle. Read data arrives one cycle after its address. On completion, pop_data = {high, low} and SP has risen by 2.
- R6: A CALL (cmd_op 2'b10) stores ret_addr using the same byte order as a PUSH and ignores push_data. On completion, pc_out equals the call_target captured at acceptance.
- R7: A RET (cmd_op 2'b11) reads a word using the POP byte order, loads it into pc_out, raises SP by 2 and leaves pop_data unchanged.
- R8: busy goes high in the cycle after acceptance. It stays high for 2 cycles for PUSH or CALL and for 3 cycles for POP or RET. done is high only in the single cycle after busy falls.
- R9: A request made while busy is ignored. It produces no memory access and no change to any register.
- R10: ptr_wr loads sp_out from ptr_sp and ss_out from ptr_ss on the next cycle. This happens only when the engine is idle and cmd_valid is low. Otherwise ptr_wr has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command request, accepted when idle |
| cmd_op | input | 2 | 00 PUSH, 01 POP, 10 CALL, 11 RET |
| push_data | input | 16 | Word to store on PUSH |
| ret_addr | input | 16 | Address of the instruction after a CALL |
| call_target | input | 16 | New program counter for CALL |
| ptr_wr | input | 1 | Direct load of the stack pointer and segment |
| ptr_sp | input | 16 | Stack pointer value for ptr_wr |
| ptr_ss | input | 16 | Segment value for ptr_wr |
| mem_addr | output | 20 | Physical byte address |
| mem_we | output | 1 | Byte write strobe |
| mem_re | output | 1 | Byte read strobe |
| mem_wdata | output | 8 | Byte write data |
| mem_rdata | input | 8 | Byte read data, valid one cycle after mem_re |
| pop_data | output | 16 | Last word retrieved by POP |
| pc_out | output | 16 | Program counter |
| sp_out | output | 16 | Stack pointer |
| ss_out | output | 16 | Stack segment |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Stored words use distinct high and low bytes, plus all-ones and all-zeros values. A swapped byte order or a byte stored at the wrong address therefore appears either in the retrieved word or in the address observed on each cycle. Back-to-back stores followed by retrievals check last-in-first-out order. Nested CALL/RET pairs confirm that the return address, not push_data, reaches the stack and comes back into the program counter. A pointer of 0x0001 makes the second byte wrap within the segment, and a segment of 0xFFFF makes the physical address overflow 20 bits; both separate correct modular arithmetic from carries into the segment. Requests and pointer loads made during a busy window must leave both the stack and the pointer untouched.

// File: rtl/stk_pkg.sv
package stk_pkg;
  localparam int WORD_W    = 16;
  localparam int BYTE_W    = 8;
  localparam int SEG_SHIFT = 4;
  localparam int PA_W      = WORD_W + SEG_SHIFT;

  typedef enum logic [1:0] {
    OP_PUSH = 2'b00,
    OP_POP  = 2'b01,
    OP_CALL = 2'b10,
    OP_RET  = 2'b11
  } stk_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_HI,
    ST_WR_LO,
    ST_RD_LO,
    ST_RD_HI,
    ST_RD_FIN
  } stk_st_e;

  // Segment shifted left plus offset, truncated to the physical width
  function automatic logic [PA_W-1:0] phys_addr(input logic [WORD_W-1:0] seg,
                                                input logic [WORD_W-1:0] off);
    logic [PA_W-1:0] seg_ext;
    logic [PA_W-1:0] off_ext;
    seg_ext = {seg, {SEG_SHIFT{1'b0}}};
    off_ext = {{SEG_SHIFT{1'b0}}, off};
    return seg_ext + off_ext;
  endfunction

  // True for commands that store a word
  function automatic logic op_stores(input stk_op_e op);
    return (op == OP_PUSH) || (op == OP_CALL);
  endfunction
endpackage

// File: rtl/stk_seq.sv
module stk_seq
  import stk_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    cmd_valid,
  input  stk_op_e cmd_op,
  output stk_st_e state,
  output stk_op_e op_q,
  output logic    accept,
  output logic    finish
);
  stk_st_e nxt;

  assign accept = cmd_valid && (state == ST_IDLE);
  assign finish = (state == ST_WR_LO) || (state == ST_RD_FIN);

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:   if (accept) nxt = op_stores(cmd_op) ? ST_WR_HI : ST_RD_LO;
      ST_WR_HI:  nxt = ST_WR_LO;
      ST_WR_LO:  nxt = ST_IDLE;
      ST_RD_LO:  nxt = ST_RD_HI;
      ST_RD_HI:  nxt = ST_RD_FIN;
      ST_RD_FIN: nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      op_q  <= OP_PUSH;
    end else begin
      state <= nxt;
      if (accept) op_q <= cmd_op;
    end
  end
endmodule

// File: rtl/stk_addr_gen.sv
module stk_addr_gen
  import stk_pkg::*;
#(
  parameter int AW = WORD_W,
  parameter int PW = PA_W
) (
  input  logic [AW-1:0] seg,
  input  logic [AW-1:0] sp,
  input  stk_st_e       state,
  output logic [PW-1:0] addr,
  output logic          we,
  output logic          re,
  output logic          hi_sel
);
  localparam logic [AW-1:0] ONE = AW'(1);
  localparam logic [AW-1:0] TWO = AW'(2);

  logic [AW-1:0] off;

  always_comb begin
    unique case (state)
      ST_WR_HI: off = sp - ONE;
      ST_WR_LO: off = sp - TWO;
      ST_RD_HI: off = sp + ONE;
      default:  off = sp;
    endcase
  end

  assign addr   = phys_addr(seg, off);
  assign we     = (state == ST_WR_HI) || (state == ST_WR_LO);
  assign re     = (state == ST_RD_LO) || (state == ST_RD_HI);
  assign hi_sel = (state == ST_WR_HI);
endmodule

// File: rtl/seg_stack_unit.sv
module seg_stack_unit
  import stk_pkg::*;
#(
  parameter logic [WORD_W-1:0] SP_RESET = '0,
  parameter logic [WORD_W-1:0] SS_RESET = '0,
  parameter logic [WORD_W-1:0] PC_RESET = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [WORD_W-1:0] push_data,
  input  logic [WORD_W-1:0] ret_addr,
  input  logic [WORD_W-1:0] call_target,
  input  logic              ptr_wr,
  input  logic [WORD_W-1:0] ptr_sp,
  input  logic [WORD_W-1:0] ptr_ss,
  output logic [PA_W-1:0]   mem_addr,
  output logic              mem_we,
  output logic              mem_re,
  output logic [BYTE_W-1:0] mem_wdata,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic [WORD_W-1:0] pop_data,
  output logic [WORD_W-1:0] pc_out,
  output logic [WORD_W-1:0] sp_out,
  output logic [WORD_W-1:0] ss_out,
  output logic              busy,
  output logic              done
);
  localparam logic [WORD_W-1:0] TWO = WORD_W'(2);

  stk_st_e state;
  stk_op_e op_q;
  stk_op_e op_in;
  logic    accept;
  logic    finish;
  logic    hi_sel;

  logic [WORD_W-1:0] sp_q, ss_q, pc_q, pop_q, wword_q, tgt_q;
  logic [BYTE_W-1:0] lo_q;
  logic              done_q;

  // Named events for the checker
  logic              fin_write;
  logic              fin_read;
  logic              ptr_take;
  logic [WORD_W-1:0] rd_word;

  assign op_in     = stk_op_e'(cmd_op);
  assign fin_write = finish && (state == ST_WR_LO);
  assign fin_read  = finish && (state == ST_RD_FIN);
  assign ptr_take  = ptr_wr && !cmd_valid && (state == ST_IDLE);
  assign rd_word   = {mem_rdata, lo_q};

  stk_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_valid(cmd_valid),
    .cmd_op   (op_in),
    .state    (state),
    .op_q     (op_q),
    .accept   (accept),
    .finish   (finish)
  );

  stk_addr_gen #(.AW(WORD_W), .PW(PA_W)) u_agen (
    .seg   (ss_q),
    .sp    (sp_q),
    .state (state),
    .addr  (mem_addr),
    .we    (mem_we),
    .re    (mem_re),
    .hi_sel(hi_sel)
  );

  assign mem_wdata = hi_sel ? wword_q[WORD_W-1:BYTE_W] : wword_q[BYTE_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q    <= SP_RESET;
      ss_q    <= SS_RESET;
      pc_q    <= PC_RESET;
      pop_q   <= '0;
      wword_q <= '0;
      tgt_q   <= '0;
      lo_q    <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= finish;
      if (accept) begin
        wword_q <= (op_in == OP_CALL) ? ret_addr : push_data;
        tgt_q   <= call_target;
      end
      if (ptr_take) begin
        sp_q <= ptr_sp;
        ss_q <= ptr_ss;
      end
      if (state == ST_RD_HI) lo_q <= mem_rdata;
      if (fin_write) begin
        sp_q <= sp_q - TWO;
        if (op_q == OP_CALL) pc_q <= tgt_q;
      end
      if (fin_read) begin
        sp_q <= sp_q + TWO;
        if (op_q == OP_RET) pc_q <= rd_word;
        else                pop_q <= rd_word;
      end
    end
  end

  assign busy     = (state != ST_IDLE);
  assign done     = done_q;
  assign sp_out   = sp_q;
  assign ss_out   = ss_q;
  assign pc_out   = pc_q;
  assign pop_data = pop_q;
endmodule

// File: rtl/seg_stack_unit_chk.sv
module seg_stack_unit_chk
  import stk_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              mem_we,
  input logic              mem_re,
  input logic [PA_W-1:0]   mem_addr,
  input logic [WORD_W-1:0] sp_out,
  input logic [WORD_W-1:0] ss_out,
  input logic              fin_write,
  input logic              fin_read
);
  localparam logic [WORD_W-1:0] ONE = WORD_W'(1);
  localparam logic [WORD_W-1:0] TWO = WORD_W'(2);

  AST_NO_RW_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n) !(mem_we && mem_re)); // R2
  AST_WR_HI_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !$past(mem_we)) |-> mem_addr == phys_addr(ss_out, sp_out - ONE)); // R2
  AST_WR_LO_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !$past(mem_we)) |=> (mem_we && mem_addr == phys_addr(ss_out, sp_out - TWO))); // R4
  AST_RD_LO_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re && !$past(mem_re)) |-> mem_addr == phys_addr(ss_out, sp_out)); // R5
  AST_SP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    fin_write |=> sp_out == $past(sp_out) - TWO); // R3
  AST_SP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    fin_read |=> sp_out == $past(sp_out) + TWO); // R5
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R8
  AST_SP_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ($stable(sp_out) && $stable(ss_out))); // R10
endmodule

bind seg_stack_unit seg_stack_unit_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .done     (done),
  .mem_we   (mem_we),
  .mem_re   (mem_re),
  .mem_addr (mem_addr),
  .sp_out   (sp_out),
  .ss_out   (ss_out),
  .fin_write(fin_write),
  .fin_read (fin_read)
);

// File: tb/seg_stack_unit_bench.sv
`timescale 1ns/1ps
module seg_stack_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'b00;
  logic [15:0] push_data = '0, ret_addr = '0, call_target = '0;
  logic        ptr_wr = 1'b0;
  logic [15:0] ptr_sp = '0, ptr_ss = '0;
  logic [19:0] mem_addr;
  logic        mem_we, mem_re;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;
  logic [15:0] pop_data, pc_out, sp_out, ss_out;
  logic        busy, done;

  int n_chk = 0;
  int n_bad = 0;
  bit ended = 0;

  logic [15:0] exp_sp = '0, exp_ss = '0, exp_pc = '0, exp_pop = '0;

  always #2 clk = ~clk;

  seg_stack_unit u_seg_stack_unit (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .push_data(push_data), .ret_addr(ret_addr), .call_target(call_target),
    .ptr_wr(ptr_wr), .ptr_sp(ptr_sp), .ptr_ss(ptr_ss),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .pop_data(pop_data), .pc_out(pc_out), .sp_out(sp_out), .ss_out(ss_out),
    .busy(busy), .done(done)
  );

  // Byte memory model with one-cycle read latency
  logic [7:0] mem_model [logic [19:0]];
  always @(posedge clk) begin
    if (mem_we) mem_model[mem_addr] = mem_wdata;
    if (mem_re) mem_rdata <= mem_model.exists(mem_addr) ? mem_model[mem_addr] : 8'h00;
  end

  function automatic logic [19:0] pa(input logic [15:0] s, input logic [15:0] o);
    int sum;
    sum = int'(s) * 16 + int'(o);
    return 20'(sum % 1048576);
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    chk("R1", "busy", 32'(busy), 32'(0));
    chk("R1", "done", 32'(done), 32'(0));
    chk("R1", "sp", 32'(sp_out), 32'(0));
    chk("R1", "ss", 32'(ss_out), 32'(0));
    chk("R1", "pc", 32'(pc_out), 32'(0));
    chk("R1", "pop", 32'(pop_data), 32'(0));
    chk("R1", "strobes", 32'({mem_we, mem_re}), 32'(0));
  endtask

  task automatic t_setptr(input logic [15:0] s, input logic [15:0] p);
    ptr_wr = 1'b1; ptr_ss = s; ptr_sp = p;
    tick();
    ptr_wr = 1'b0;
    exp_ss = s; exp_sp = p;
    chk("R10", "sp load", 32'(sp_out), 32'(p));
    chk("R10", "ss load", 32'(ss_out), 32'(s));
  endtask

  // PUSH or CALL
  task automatic t_write(input logic is_call, input logic [15:0] word, input logic [15:0] tgt);
    logic [15:0] sp0;
    string req;
    sp0 = exp_sp;
    req = is_call ? "R6" : "R2";
    cmd_valid = 1'b1;
    cmd_op = is_call ? 2'b10 : 2'b00;
    push_data = is_call ? ~word : word;
    ret_addr = is_call ? word : ~word;
    call_target = tgt;
    tick();
    cmd_valid = 1'b0;
    chk("R8", "busy first", 32'(busy), 32'(1));
    chk(req, "we hi", 32'(mem_we), 32'(1));
    chk("R4", "addr hi", 32'(mem_addr), 32'(pa(exp_ss, sp0 - 16'd1)));
    chk(req, "data hi", 32'(mem_wdata), 32'(word[15:8]));
    tick();
    chk(req, "we lo", 32'(mem_we), 32'(1));
    chk("R4", "addr lo", 32'(mem_addr), 32'(pa(exp_ss, sp0 - 16'd2)));
    chk(req, "data lo", 32'(mem_wdata), 32'(word[7:0]));
    tick();
    exp_sp = sp0 - 16'd2;
    if (is_call) exp_pc = tgt;
    chk("R8", "done", 32'({busy, done}), 32'(2'b01));
    chk("R3", "sp after store", 32'(sp_out), 32'(exp_sp));
    chk("R6", "pc", 32'(pc_out), 32'(exp_pc));
    tick();
    chk("R8", "done single", 32'(done), 32'(0));
  endtask

  // POP or RET
  task automatic t_read(input logic is_ret, input logic [15:0] word);
    logic [15:0] sp0;
    string req;
    sp0 = exp_sp;
    req = is_ret ? "R7" : "R5";
    cmd_valid = 1'b1;
    cmd_op = is_ret ? 2'b11 : 2'b01;
    tick();
    cmd_valid = 1'b0;
    chk(req, "re lo", 32'(mem_re), 32'(1));
    chk("R4", "addr lo", 32'(mem_addr), 32'(pa(exp_ss, sp0)));
    tick();
    chk(req, "re hi", 32'(mem_re), 32'(1));
    chk("R4", "addr hi", 32'(mem_addr), 32'(pa(exp_ss, sp0 + 16'd1)));
    tick();
    chk("R8", "busy third", 32'({busy, mem_re}), 32'(2'b10));
    tick();
    exp_sp = sp0 + 16'd2;
    if (is_ret) exp_pc = word;
    else        exp_pop = word;
    chk("R8", "done", 32'({busy, done}), 32'(2'b01));
    chk(req, "sp after read", 32'(sp_out), 32'(exp_sp));
    chk(req, "pop_data", 32'(pop_data), 32'(exp_pop));
    chk(req, "pc", 32'(pc_out), 32'(exp_pc));
    tick();
    chk("R8", "done single", 32'(done), 32'(0));
  endtask

  // Requests and pointer loads during busy must be ignored
  task automatic t_ignore();
    logic [15:0] sp0;
    sp0 = exp_sp;
    cmd_valid = 1'b1; cmd_op = 2'b00; push_data = 16'h5A5A;
    tick();
    cmd_op = 2'b01; ptr_wr = 1'b1; ptr_sp = 16'h9999; ptr_ss = 16'h7777;
    tick();
    tick();
    cmd_valid = 1'b0; ptr_wr = 1'b0;
    exp_sp = sp0 - 16'd2;
    chk("R9", "sp after ignored pop", 32'(sp_out), 32'(exp_sp));
    chk("R10", "ss unchanged", 32'(ss_out), 32'(exp_ss));
    tick();
    chk("R9", "no new command", 32'({busy, mem_re, mem_we}), 32'(0));
    t_read(1'b0, 16'h5A5A);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    tick();
    t_reset();

    t_setptr(16'h1000, 16'h0100);
    t_write(1'b0, 16'h1234, 16'h0);
    t_write(1'b0, 16'hA55A, 16'h0);
    t_read(1'b0, 16'hA55A);
    t_read(1'b0, 16'h1234);
    t_write(1'b0, 16'hFFFF, 16'h0);
    t_write(1'b0, 16'h0000, 16'h0);
    t_read(1'b0, 16'h0000);
    t_read(1'b0, 16'hFFFF);

    t_write(1'b1, 16'h0456, 16'h2000);
    t_read(1'b1, 16'h0456);
    t_write(1'b1, 16'h3003, 16'h4000);
    t_write(1'b1, 16'h4004, 16'h5000);
    t_read(1'b1, 16'h4004);
    t_read(1'b1, 16'h3003);

    t_setptr(16'h2000, 16'h0001);
    t_write(1'b0, 16'hBEEF, 16'h0);
    t_read(1'b0, 16'hBEEF);
    t_setptr(16'hFFFF, 16'h0020);
    t_write(1'b0, 16'h7E81, 16'h0);
    t_read(1'b0, 16'h7E81);

    t_setptr(16'h1000, 16'h0200);
    t_ignore();

    ended = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule